// File: doc/BRIEF.md
# Framed Debug-Link Byte Receiver

This block sits behind a byte-wide serial receiver and turns its stream of bytes into framed messages. It searches the stream for a start marker. It then gathers a little-endian 16-bit sequence number and a little-endian 32-bit body length, and checks a fixed token byte. Next it passes the body bytes straight through with first and last markers, and finally compares a trailing 16-bit checksum. At the end of every frame that reaches its checksum, the block gives a one-cycle completion pulse with a good/bad verdict, the sequence number, an unsolicited-event flag and the class of the first body byte.

Frames that break the header rules are dropped without a completion pulse, and hunting starts again. These are a wrong token, a zero length, a length above the configured limit, or a stall longer than the programmable idle limit. Two saturating counters record checksum failures and header or timeout failures.

The control is a six-state machine:

| State | Role |
|-------|------|
| ST_HUNT | Waits for the start marker. |
| ST_SEQ | Takes in the 2 sequence bytes. |
| ST_LEN | Takes in the 4 length bytes. |
| ST_TOKEN | Checks the token byte. |
| ST_BODY | Streams the body bytes. |
| ST_CRC | Takes in the 2 checksum bytes. |

Its transitions are:

| From | To | Condition |
|------|----|-----------|
| ST_HUNT | ST_SEQ | The start marker arrives. |
| ST_SEQ | ST_LEN | The second sequence byte arrives. |
| ST_LEN | ST_TOKEN | The fourth length byte arrives and the length is legal. |
| ST_LEN | ST_HUNT | The fourth length byte arrives and the length is illegal. |
| ST_TOKEN | ST_BODY | The token byte matches. |
| ST_TOKEN | ST_HUNT | The token byte does not match. |
| ST_BODY | ST_CRC | The last body byte arrives. |
| ST_CRC | ST_HUNT | The second checksum byte arrives; the completion pulse follows. |
| any state except ST_HUNT | ST_HUNT | The idle timeout expires. |

Top module: `dbg_frame_rx`

## Requirements
- R1: While hunting, every byte other than 0x1B is discarded with no output, and a 0x1B byte opens a frame.
- R2: The two bytes after 0x1B form the sequence number, low byte first. The next four bytes form the body length, low byte first. `seq_num` shows the sequence number while `frame_done` is high.
- R3: The byte after the length must be 0x0E. Any other value drops the frame without `frame_done`, adds one to the parse-error counter, and returns the block to hunting.
- R4: A length of zero, or a length above `MAX_LEN` (default 100000), is rejected when the fourth length byte arrives. The frame is dropped, no body byte is output, and the parse-error counter adds one.
- R5: Each body byte appears on `body_data` with `body_valid` one cycle after it is accepted. `body_first` marks the first body byte and `body_last` marks the byte that completes the length.
- R6: The checksum is reflected CRC-16 with polynomial 0x8408, initial value 0xFFFF and no final inversion. It covers every byte from the 0x1B through the last body byte. It is compared with the two trailing bytes, low byte first. One cycle after the second of these bytes, `frame_done` pulses for one cycle, and `frame_ok` is high with it only on a match.
- R7: `evt_frame` is high with `frame_done` exactly when the sequence number is 0xFFFF.
- R8: `msg_class` shows the class of the first body byte while `frame_done` is high. The classes are: 0 for 0x00–0x3F (command), 1 for 0x40–0x7F (internal), 2 for 0x80–0x9F (success), 3 for 0xA0–0xBF (failure), 4 for 0xE0–0xFF (event), and 5 for 0xC0–0xDF (unknown).
- R9: When `timeout_limit` is nonzero and a frame is open, more than `timeout_limit` consecutive clocks without `in_valid` drop the frame. The block returns to hunting and the parse-error counter adds one. A value of 0 turns the timeout off.
- R10: `crc_err_cnt` adds one for each frame that fails its checksum. `parse_err_cnt` adds one for each R3, R4 or R9 drop. Both counters start at 0, step by one, and hold at all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte is present this cycle |
| in_data | input | 8 | Input byte |
| timeout_limit | input | TO_W | Idle clocks allowed inside a frame; 0 turns the timeout off |
| body_valid | output | 1 | Body byte on `body_data` is valid |
| body_data | output | 8 | Body byte |
| body_first | output | 1 | First body byte of the frame |
| body_last | output | 1 | Last body byte of the frame |
| frame_done | output | 1 | One-cycle pulse at the end of a checked frame |
| frame_ok | output | 1 | Checksum matched; valid with `frame_done` |
| seq_num | output | 16 | Sequence number of the completed frame |
| evt_frame | output | 1 | Completed frame carried sequence number 0xFFFF |
| msg_class | output | 3 | Class of the first body byte (encoding in R8) |
| crc_err_cnt | output | CNT_W | Saturating count of checksum failures |
| parse_err_cnt | output | CNT_W | Saturating count of header and timeout drops |

## Verification
The hardest conditions to reach from the ports are the length guard and counter saturation. The length guard must fire before any body byte appears. Saturation would need hundreds of bad frames at the default counter width. The bench sends a header whose length is one above the limit and follows it with a token and body-like bytes, then confirms that none of them reach the body output. The bench builds the block with a 3-bit counter width, so a short run of bad-token frames drives the parse counter to all ones. Random frames with random gaps, garbage before the start marker and random first bytes are mixed with directed frames at each class boundary, a 0xFFFF sequence number, a corrupted checksum and an idle stall.

// File: rtl/dfr_pkg.sv
package dfr_pkg;
    localparam logic [7:0] START_BYTE = 8'h1B;
    localparam logic [7:0] TOKEN_BYTE = 8'h0E;
    localparam logic [15:0] CRC_SEED  = 16'hFFFF;
    localparam logic [15:0] EVT_SEQ   = 16'hFFFF;

    typedef enum logic [2:0] {
        ST_HUNT, ST_SEQ, ST_LEN, ST_TOKEN, ST_BODY, ST_CRC
    } rx_state_t;

    typedef enum logic [2:0] {
        CLS_CMD  = 3'd0,
        CLS_INT  = 3'd1,
        CLS_OK   = 3'd2,
        CLS_FAIL = 3'd3,
        CLS_EVT  = 3'd4,
        CLS_UNK  = 3'd5
    } code_class_t;
endpackage

// File: rtl/dfr_crc_step.sv
module dfr_crc_step
    import dfr_pkg::*;
#(
    parameter logic [15:0] POLY = 16'h8408
) (
    input  logic [15:0] crc_in,
    input  logic [7:0]  data,
    output logic [15:0] crc_out
);
    always_comb begin
        logic [15:0] c;
        c = crc_in ^ {8'h00, data};
        for (int i = 0; i < 8; i++) begin
            c = c[0] ? ((c >> 1) ^ POLY) : (c >> 1);
        end
        crc_out = c;
    end
endmodule

// File: rtl/dfr_classify.sv
module dfr_classify
    import dfr_pkg::*;
(
    input  logic [7:0]  code,
    output code_class_t cls
);
    always_comb begin
        unique case (code[7:5])
            3'b000, 3'b001: cls = CLS_CMD;
            3'b010, 3'b011: cls = CLS_INT;
            3'b100:         cls = CLS_OK;
            3'b101:         cls = CLS_FAIL;
            3'b110:         cls = CLS_UNK;
            default:        cls = CLS_EVT;
        endcase
    end
endmodule

// File: rtl/dfr_sat_cnt.sv
module dfr_sat_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt <= '0;
        else if (inc && cnt != TOP) cnt <= cnt + ONE;
    end
endmodule

// File: rtl/dbg_frame_rx.sv
module dbg_frame_rx
    import dfr_pkg::*;
#(
    parameter int unsigned MAX_LEN = 100000,
    parameter int          TO_W    = 16,
    parameter int          CNT_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic [TO_W-1:0]  timeout_limit,
    output logic             body_valid,
    output logic [7:0]       body_data,
    output logic             body_first,
    output logic             body_last,
    output logic             frame_done,
    output logic             frame_ok,
    output logic [15:0]      seq_num,
    output logic             evt_frame,
    output logic [2:0]       msg_class,
    output logic [CNT_W-1:0] crc_err_cnt,
    output logic [CNT_W-1:0] parse_err_cnt
);
    localparam logic [TO_W-1:0] TO_ONE = {{(TO_W-1){1'b0}}, 1'b1};
    localparam logic [TO_W-1:0] TO_TOP = {TO_W{1'b1}};

    rx_state_t     state_q, state_d;
    logic [1:0]    idx_q;
    logic [15:0]   seq_q;
    logic [31:0]   len_q, rem_q;
    logic [15:0]   crc_q, crc_src, crc_nxt;
    logic [7:0]    crc_lo_q;
    code_class_t   cls_q, cls_in;
    logic [TO_W-1:0] idle_q;

    logic [31:0]   len_full;
    logic          len_bad, timeout_hit, crc_match;
    logic          parse_err_p, frame_end_p;

    assign crc_src = (state_q == ST_HUNT) ? CRC_SEED : crc_q;

    dfr_crc_step u_crc (.crc_in(crc_src), .data(in_data), .crc_out(crc_nxt));
    dfr_classify u_cls (.code(in_data), .cls(cls_in));

    assign len_full    = {in_data, len_q[31:8]};
    assign len_bad     = (len_full == 32'd0) || (len_full > MAX_LEN);
    assign timeout_hit = (state_q != ST_HUNT) && !in_valid &&
                         (timeout_limit != '0) && (idle_q >= timeout_limit);
    assign crc_match   = ({in_data, crc_lo_q} == crc_q);

    // next-state and event decode
    always_comb begin
        state_d     = state_q;
        parse_err_p = 1'b0;
        frame_end_p = 1'b0;
        if (timeout_hit) begin
            state_d     = ST_HUNT;
            parse_err_p = 1'b1;
        end else if (in_valid) begin
            unique case (state_q)
                ST_HUNT:  if (in_data == START_BYTE) state_d = ST_SEQ;
                ST_SEQ:   if (idx_q == 2'd1) state_d = ST_LEN;
                ST_LEN:   if (idx_q == 2'd3) begin
                              if (len_bad) begin
                                  state_d     = ST_HUNT;
                                  parse_err_p = 1'b1;
                              end else begin
                                  state_d = ST_TOKEN;
                              end
                          end
                ST_TOKEN: if (in_data == TOKEN_BYTE) state_d = ST_BODY;
                          else begin
                              state_d     = ST_HUNT;
                              parse_err_p = 1'b1;
                          end
                ST_BODY:  if (rem_q == 32'd1) state_d = ST_CRC;
                ST_CRC:   if (idx_q == 2'd1) begin
                              state_d     = ST_HUNT;
                              frame_end_p = 1'b1;
                          end
                default:  state_d = ST_HUNT;
            endcase
        end
    end

    // state register and frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_HUNT;
            idx_q    <= '0;
            seq_q    <= '0;
            len_q    <= '0;
            rem_q    <= '0;
            crc_q    <= CRC_SEED;
            crc_lo_q <= '0;
            cls_q    <= CLS_UNK;
            idle_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= (state_d != state_q) ? 2'd0 : idx_q + 2'(in_valid);
            if (in_valid || state_q == ST_HUNT) idle_q <= '0;
            else if (idle_q != TO_TOP)          idle_q <= idle_q + TO_ONE;
            if (in_valid) begin
                if (state_q != ST_CRC) crc_q <= crc_nxt;
                unique case (state_q)
                    ST_SEQ:  seq_q <= {in_data, seq_q[15:8]};
                    ST_LEN:  begin
                                 len_q <= len_full;
                                 rem_q <= len_full;
                             end
                    ST_BODY: begin
                                 rem_q <= rem_q - 32'd1;
                                 if (rem_q == len_q) cls_q <= cls_in;
                             end
                    ST_CRC:  crc_lo_q <= in_data;
                    default: ;
                endcase
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            body_valid <= 1'b0;
            body_data  <= '0;
            body_first <= 1'b0;
            body_last  <= 1'b0;
            frame_done <= 1'b0;
            frame_ok   <= 1'b0;
            seq_num    <= '0;
            evt_frame  <= 1'b0;
            msg_class  <= '0;
        end else begin
            body_valid <= (state_q == ST_BODY) && in_valid;
            body_data  <= in_data;
            body_first <= (state_q == ST_BODY) && in_valid && (rem_q == len_q);
            body_last  <= (state_q == ST_BODY) && in_valid && (rem_q == 32'd1);
            frame_done <= frame_end_p;
            frame_ok   <= frame_end_p && crc_match;
            if (frame_end_p) begin
                seq_num   <= seq_q;
                evt_frame <= (seq_q == EVT_SEQ);
                msg_class <= cls_q;
            end
        end
    end

    dfr_sat_cnt #(.W(CNT_W)) u_crc_cnt (
        .clk(clk), .rst_n(rst_n), .inc(frame_end_p && !crc_match), .cnt(crc_err_cnt)
    );
    dfr_sat_cnt #(.W(CNT_W)) u_parse_cnt (
        .clk(clk), .rst_n(rst_n), .inc(parse_err_p), .cnt(parse_err_cnt)
    );
endmodule

// File: rtl/dfr_rx_checker.sv
module dfr_rx_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             body_valid,
    input logic             body_first,
    input logic             body_last,
    input logic             frame_done,
    input logic             frame_ok,
    input logic [CNT_W-1:0] crc_err_cnt,
    input logic [CNT_W-1:0] parse_err_cnt
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    a_r5_first_in_valid: assert property (@(posedge clk) disable iff (!rst_n)
        body_first |-> body_valid);
    a_r5_last_in_valid: assert property (@(posedge clk) disable iff (!rst_n)
        body_last |-> body_valid);
    a_r6_ok_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |-> frame_done);
    a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
    a_r6_no_body_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        body_valid |-> !frame_done);
    a_r10_crc_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_err_cnt != $past(crc_err_cnt)) |-> (crc_err_cnt == $past(crc_err_cnt) + ONE));
    a_r10_crc_cnt_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_err_cnt != $past(crc_err_cnt)) |-> (frame_done && !frame_ok));
    a_r10_parse_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        (parse_err_cnt != $past(parse_err_cnt)) |-> (parse_err_cnt == $past(parse_err_cnt) + ONE));
endmodule

bind dbg_frame_rx dfr_rx_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .body_valid(body_valid), .body_first(body_first),
    .body_last(body_last), .frame_done(frame_done), .frame_ok(frame_ok),
    .crc_err_cnt(crc_err_cnt), .parse_err_cnt(parse_err_cnt)
);

// File: tb/dbg_frame_rx_tb_top.sv
`timescale 1ns/1ps
module dbg_frame_rx_tb_top;
    localparam int CW = 3;
    localparam int TW = 16;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic [TW-1:0] timeout_limit = 16'd16;
    logic body_valid, body_first, body_last, frame_done, frame_ok, evt_frame;
    logic [7:0] body_data;
    logic [15:0] seq_num;
    logic [2:0] msg_class;
    logic [CW-1:0] crc_err_cnt, parse_err_cnt;

    always #2 clk = ~clk;

    dbg_frame_rx #(.MAX_LEN(100000), .TO_W(TW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .timeout_limit(timeout_limit), .body_valid(body_valid), .body_data(body_data),
        .body_first(body_first), .body_last(body_last), .frame_done(frame_done),
        .frame_ok(frame_ok), .seq_num(seq_num), .evt_frame(evt_frame),
        .msg_class(msg_class), .crc_err_cnt(crc_err_cnt), .parse_err_cnt(parse_err_cnt)
    );

    int n_chk = 0, n_bad = 0;
    int exp_crc = 0, exp_parse = 0;
    logic [7:0] fb [0:63];
    int fb_n;
    logic [7:0] rx [0:63];
    int rx_n, first_n, last_n, done_n;
    logic got_ok, got_evt;
    logic [15:0] got_seq;
    logic [2:0] got_cls;

    // monitor, sampling away from the active edge
    always @(negedge clk) begin
        if (body_valid) begin
            if (rx_n < 64) rx[rx_n] = body_data;
            rx_n = rx_n + 1;
            if (body_first) first_n = first_n + 1;
            if (body_last)  last_n  = last_n + 1;
        end
        if (frame_done) begin
            done_n  = done_n + 1;
            got_ok  = frame_ok;
            got_evt = evt_frame;
            got_seq = seq_num;
            got_cls = msg_class;
        end
    end

    task automatic chk(input bit good, input string req, input longint act, input longint exp);
        n_chk++;
        if (!good) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c ^ {8'h00, d};
        for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
        return r;
    endfunction

    function automatic logic [2:0] cls_of(input logic [7:0] b);
        if (b <= 8'h3F) return 3'd0;
        if (b <= 8'h7F) return 3'd1;
        if (b <= 8'h9F) return 3'd2;
        if (b <= 8'hBF) return 3'd3;
        if (b <= 8'hDF) return 3'd5;
        return 3'd4;
    endfunction

    function automatic int sat(input int v);
        return (v > CMAX) ? CMAX : v;
    endfunction

    task automatic clr_mon();
        rx_n = 0; first_n = 0; last_n = 0; done_n = 0;
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk); in_valid = 1'b1; in_data = b;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin @(negedge clk); in_valid = 1'b0; end
    endtask

    // build a frame into fb: header, body (len bytes, first = code), checksum
    task automatic build(input logic [15:0] sq, input int len, input logic [7:0] code,
                         input logic [7:0] tok, input bit bad_crc);
        logic [15:0] c;
        fb[0] = 8'h1B; fb[1] = sq[7:0]; fb[2] = sq[15:8];
        fb[3] = len[7:0]; fb[4] = len[15:8]; fb[5] = len[23:16]; fb[6] = len[31:24];
        fb[7] = tok;
        for (int i = 0; i < len; i++) fb[8+i] = (i == 0) ? code : 8'($urandom);
        c = 16'hFFFF;
        for (int i = 0; i < 8 + len; i++) c = crc_upd(c, fb[i]);
        if (bad_crc) c = c ^ 16'h0100;
        fb[8+len] = c[7:0]; fb[9+len] = c[15:8];
        fb_n = 10 + len;
    endtask

    task automatic send_fb(input bit gaps);
        for (int i = 0; i < fb_n; i++) begin
            if (gaps) idle(int'($urandom % 3));
            put(fb[i]);
        end
        idle(4);
    endtask

    task automatic good_frame(input logic [15:0] sq, input int len, input logic [7:0] code,
                              input bit gaps, input string tag);
        bit body_ok;
        build(sq, len, code, 8'h0E, 1'b0);
        clr_mon();
        send_fb(gaps);
        body_ok = (rx_n == len);
        for (int i = 0; i < len && i < 64; i++) if (rx[i] != fb[8+i]) body_ok = 0;
        chk(done_n == 1 && got_ok, {tag, " R6 good frame done/ok"}, done_n, 1);
        chk(got_seq == sq, {tag, " R2 seq"}, got_seq, sq);
        chk(body_ok && first_n == 1 && last_n == 1, {tag, " R5 body stream"}, rx_n, len);
        chk(got_cls == cls_of(code), {tag, " R8 class"}, got_cls, cls_of(code));
        chk(got_evt == (sq == 16'hFFFF), {tag, " R7 event flag"}, got_evt, sq == 16'hFFFF);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk(body_valid == 0 && frame_done == 0, "R5 reset outputs idle", body_valid, 0);
        chk(crc_err_cnt == 0 && parse_err_cnt == 0, "R10 counters zero at reset", crc_err_cnt, 0);
        rst_n = 1'b1;
        idle(2);

        // R1: garbage before a frame
        clr_mon();
        for (int i = 0; i < 20; i++) begin
            logic [7:0] g;
            g = 8'($urandom);
            if (g == 8'h1B) g = 8'h00;
            put(g);
        end
        idle(4);
        chk(rx_n == 0 && done_n == 0, "R1 garbage discarded", rx_n + done_n, 0);
        good_frame(16'h1234, 3, 8'h05, 1'b0, "R1 after garbage");

        // class boundaries
        good_frame(16'h0001, 1, 8'h3F, 1'b0, "bnd3F");
        good_frame(16'h0002, 2, 8'h40, 1'b0, "bnd40");
        good_frame(16'h0003, 2, 8'h7F, 1'b0, "bnd7F");
        good_frame(16'h0004, 2, 8'h80, 1'b0, "bnd80");
        good_frame(16'h0005, 2, 8'h9F, 1'b0, "bnd9F");
        good_frame(16'h0006, 2, 8'hA0, 1'b0, "bndA0");
        good_frame(16'h0007, 2, 8'hBF, 1'b0, "bndBF");
        good_frame(16'h0008, 2, 8'hC0, 1'b0, "bndC0");
        good_frame(16'h0009, 2, 8'hDF, 1'b0, "bndDF");
        good_frame(16'h000A, 2, 8'hE0, 1'b0, "bndE0");
        good_frame(16'hFFFF, 4, 8'hFF, 1'b0, "R7 event seq");

        // random frames with gaps
        for (int k = 0; k < 30; k++)
            good_frame(16'($urandom), 1 + int'($urandom % 24), 8'($urandom), 1'b1, "rand");

        // R6: corrupted checksum
        build(16'hBEEF, 5, 8'h81, 8'h0E, 1'b1);
        clr_mon(); send_fb(1'b0);
        exp_crc++;
        chk(done_n == 1 && !got_ok, "R6 bad crc reported", got_ok, 0);
        chk(crc_err_cnt == sat(exp_crc), "R10 crc counter", crc_err_cnt, sat(exp_crc));

        // R3: wrong token
        build(16'h0042, 3, 8'h10, 8'h0F, 1'b0);
        clr_mon(); send_fb(1'b0);
        exp_parse++;
        chk(done_n == 0 && rx_n == 0, "R3 bad token dropped", done_n + rx_n, 0);
        chk(parse_err_cnt == sat(exp_parse), "R3 parse counter", parse_err_cnt, sat(exp_parse));
        good_frame(16'h0043, 3, 8'h10, 1'b0, "R3 recover");

        // R4: zero length
        clr_mon();
        put(8'h1B); put(8'h01); put(8'h00);
        put(8'h00); put(8'h00); put(8'h00); put(8'h00);
        put(8'h0E); put(8'h22); put(8'h33); idle(4);
        exp_parse++;
        chk(done_n == 0 && rx_n == 0, "R4 zero length dropped", rx_n, 0);
        chk(parse_err_cnt == sat(exp_parse), "R4 zero length counted", parse_err_cnt, sat(exp_parse));

        // R4: length MAX_LEN+1 = 100001 = 0x000186A1
        clr_mon();
        put(8'h1B); put(8'h02); put(8'h00);
        put(8'hA1); put(8'h86); put(8'h01); put(8'h00);
        put(8'h0E);
        for (int i = 0; i < 6; i++) put(8'h55);
        idle(4);
        exp_parse++;
        chk(rx_n == 0 && done_n == 0, "R4 oversize no body", rx_n, 0);
        chk(parse_err_cnt == sat(exp_parse), "R4 oversize counted", parse_err_cnt, sat(exp_parse));
        good_frame(16'h0044, 6, 8'h90, 1'b0, "R4 recover");

        // R9: stall inside a frame
        clr_mon();
        put(8'h1B); put(8'h07); put(8'h00); put(8'h02);
        idle(24);
        exp_parse++;
        chk(parse_err_cnt == sat(exp_parse), "R9 timeout counted", parse_err_cnt, sat(exp_parse));
        good_frame(16'h0045, 2, 8'hE5, 1'b0, "R9 recover");
        // gap just under the limit survives
        build(16'h0046, 2, 8'h01, 8'h0E, 1'b0);
        clr_mon();
        for (int i = 0; i < fb_n; i++) begin idle(12); put(fb[i]); end
        idle(4);
        chk(done_n == 1 && got_ok, "R9 short gaps tolerated", done_n, 1);

        // R10: saturation of parse counter
        for (int k = 0; k < 8; k++) begin
            build(16'(k), 2, 8'h01, 8'hAA, 1'b0);
            send_fb(1'b0);
            exp_parse++;
        end
        chk(parse_err_cnt == CMAX, "R10 parse counter saturates", parse_err_cnt, CMAX);
        good_frame(16'h0047, 2, 8'h01, 1'b0, "R10 after saturation");

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule